// File: doc/BRIEF.md
# Trap Mask and Cause Register Unit

This unit keeps two registers for a small processor's trap mechanism: a cause register that records which events have happened, and a mask register that decides which recorded events may interrupt the program. A trap request goes out whenever a recorded cause bit meets an enabled mask bit. Software reads both registers on dedicated output buses. It writes them through write ports that carry a separate enable for each bit.

The event classes do not share one masking rule, and handling each of them correctly is the purpose of the block.

- **I/O interrupts and access violations** are always recorded. Their mask bit only holds back delivery, so a pending bit traps as soon as its mask bit is set, even if that happens later.
- **Security events** are always recorded and always delivered. Each one also turns its own mask bit on.
- **Privilege events** are treated differently. They are not recorded at all while their mask bit is 0. They are also not recorded when the offending instruction sits at a negative (privileged) address.

All pins are plain control and status signals. There is no streaming interface, so no valid/ready back-pressure applies.

Bit layout (default parameters):

| Bits | Use |
|------|-----|
| 7..0 | I/O interrupt lines |
| 10..8 | Access violations: read, write, execute |
| 11 | Privilege event |
| 12 | Security event |
| 63..13 | Software storage with no event source |

Top module: `tmc_unit`

## Requirements
- R1: After a synchronous active-low reset, the cause register, the mask register and the trap request are all zero.
- R2: An active I/O line sets its cause bit (bits 7..0) whatever the mask holds. The bit then stays 1 until software clears it.
- R3: The trap request is high in every cycle in which some I/O or access cause bit and the mask bit at the same position are both 1. This includes the case where the mask bit is set after the cause bit.
- R4: A security event sets cause bit 12 and mask bit 12 at the next clock edge, even when mask bit 12 was 0, and the trap request goes high.
- R5: A pending security cause bit (bit 12) requests a trap even after software has cleared mask bit 12.
- R6: While mask bit 11 is 0, a privilege event leaves cause bit 11 unchanged and raises no trap.
- R7: With mask bit 11 set, a privilege event records cause bit 11 (and traps) only when the address-sign input is 0. When the address-sign input is 1 (a negative, privileged address), the event is ignored.
- R8: A software write changes exactly the bits whose write-enable bit is 1, across the full 64-bit width, and leaves all other bits as they were.
- R9: When a software write and an event hit the same bit in the same cycle, a write of 0 wins and the bit ends at 0. A write of 1 leaves the bit at 1.
- R10: An access-violation pulse (read, write, execute on bits 8, 9, 10) sets its cause bit with the mask bit clear, without trapping. It traps once the mask bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_req | input | 8 | I/O interrupt request lines |
| acc_evt | input | 3 | Access violation pulses: read, write, execute |
| priv_evt | input | 1 | Privilege violation pulse |
| pc_neg | input | 1 | Sign bit of the current instruction address |
| sec_evt | input | 1 | Security violation pulse |
| cause_we | input | 64 | Per-bit write enable, cause register |
| cause_wd | input | 64 | Write data, cause register |
| mask_we | input | 64 | Per-bit write enable, mask register |
| mask_wd | input | 64 | Write data, mask register |
| cause_q | output | 64 | Current cause register |
| mask_q | output | 64 | Current mask register |
| trap_req | output | 1 | Trap request |

## Verification

Every event and every write lands in a register at the next rising edge. The trap request is combinational from those registers, so it is due in the same cycle as the register change.

Each stimulus is applied 2 ns after a rising edge and held for exactly one edge. The bench then samples 2 ns after that edge, when both registers and the trap request have settled.

The collision cases place a write and an event on the same edge. This makes the clear-priority rule visible at the outputs.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  localparam int unsigned REG_W   = 64;
  localparam int unsigned IO_W    = 8;
  localparam int unsigned ACC_W   = 3;
  localparam int unsigned IO_LSB  = 0;
  localparam int unsigned ACC_LSB = IO_LSB + IO_W;
  localparam int unsigned PRV_BIT = ACC_LSB + ACC_W;
  localparam int unsigned SEC_BIT = PRV_BIT + 1;
endpackage

// File: rtl/tmc_event_map.sv
module tmc_event_map #(
  parameter int unsigned W       = 64,
  parameter int unsigned IO_W    = 8,
  parameter int unsigned ACC_W   = 3,
  parameter int unsigned IO_LSB  = 0,
  parameter int unsigned ACC_LSB = 8,
  parameter int unsigned PRV_BIT = 11,
  parameter int unsigned SEC_BIT = 12
) (
  input  logic [IO_W-1:0]  io_req,
  input  logic [ACC_W-1:0] acc_evt,
  input  logic             priv_evt,
  input  logic             pc_neg,
  input  logic             sec_evt,
  input  logic [W-1:0]     mask_q,
  output logic [W-1:0]     cause_set,
  output logic [W-1:0]     mask_set
);
  always_comb begin
    cause_set = '0;
    mask_set  = '0;
    cause_set[IO_LSB +: IO_W]   = io_req;
    cause_set[ACC_LSB +: ACC_W] = acc_evt;
    // privilege events are suppressed, not merely held back
    cause_set[PRV_BIT] = priv_evt & ~pc_neg & mask_q[PRV_BIT];
    cause_set[SEC_BIT] = sec_evt;
    // a security event enables its own delivery
    mask_set[SEC_BIT]  = sec_evt;
  end
endmodule

// File: rtl/tmc_sticky_reg.sv
module tmc_sticky_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  // written bits take the write data; others accumulate events
  always_comb nxt = (we & wd) | (~we & (q | set));

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R1
  rst_zero_chk: assert property (@(posedge clk) $rose(rst_n) |-> q == '0);

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(q) & ~$past(we & ~wd) & ~q) == '0));

  // R9
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(we & ~wd)) |=> ((q & $past(we & ~wd)) == '0));
endmodule

// File: rtl/tmc_trap_eval.sv
module tmc_trap_eval #(
  parameter int unsigned W       = 64,
  parameter int unsigned SEC_BIT = 12
) (
  input  logic [W-1:0] cause_q,
  input  logic [W-1:0] mask_q,
  output logic         trap_req
);
  logic [W-1:0] eff_mask;
  logic [W-1:0] hit;

  always_comb begin
    eff_mask          = mask_q;
    eff_mask[SEC_BIT] = 1'b1;
  end

  for (genvar i = 0; i < W; i++) begin : g_hit
    assign hit[i] = cause_q[i] & eff_mask[i];
  end

  assign trap_req = |hit;
endmodule

// File: rtl/tmc_unit.sv
module tmc_unit
  import tmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_W-1:0]   io_req,
  input  logic [ACC_W-1:0]  acc_evt,
  input  logic              priv_evt,
  input  logic              pc_neg,
  input  logic              sec_evt,
  input  logic [REG_W-1:0]  cause_we,
  input  logic [REG_W-1:0]  cause_wd,
  input  logic [REG_W-1:0]  mask_we,
  input  logic [REG_W-1:0]  mask_wd,
  output logic [REG_W-1:0]  cause_q,
  output logic [REG_W-1:0]  mask_q,
  output logic              trap_req
);
  logic [REG_W-1:0] cause_set;
  logic [REG_W-1:0] mask_set;

  tmc_event_map #(
    .W(REG_W), .IO_W(IO_W), .ACC_W(ACC_W), .IO_LSB(IO_LSB),
    .ACC_LSB(ACC_LSB), .PRV_BIT(PRV_BIT), .SEC_BIT(SEC_BIT)
  ) u_map (
    .io_req(io_req), .acc_evt(acc_evt), .priv_evt(priv_evt),
    .pc_neg(pc_neg), .sec_evt(sec_evt), .mask_q(mask_q),
    .cause_set(cause_set), .mask_set(mask_set)
  );

  tmc_sticky_reg #(.W(REG_W)) u_cause (
    .clk(clk), .rst_n(rst_n), .set(cause_set),
    .we(cause_we), .wd(cause_wd), .q(cause_q)
  );

  tmc_sticky_reg #(.W(REG_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .set(mask_set),
    .we(mask_we), .wd(mask_wd), .q(mask_q)
  );

  tmc_trap_eval #(.W(REG_W), .SEC_BIT(SEC_BIT)) u_eval (
    .cause_q(cause_q), .mask_q(mask_q), .trap_req(trap_req)
  );

  // R4
  sec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && !(cause_we[SEC_BIT] && !cause_wd[SEC_BIT])
             && !(mask_we[SEC_BIT] && !mask_wd[SEC_BIT]))
    |=> (cause_q[SEC_BIT] && mask_q[SEC_BIT]));

  // R5
  sec_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[SEC_BIT] |-> trap_req);

  // R6
  prv_nomask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q[PRV_BIT] && !cause_we[PRV_BIT]) |=> !$rose(cause_q[PRV_BIT]));

  // R7
  prv_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_neg && !cause_we[PRV_BIT]) |=> !$rose(cause_q[PRV_BIT]));

  // R3
  io_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cause_q[IO_LSB +: IO_W] & mask_q[IO_LSB +: IO_W])) |-> trap_req);
endmodule

// File: tb/tmc_unit_tb.sv
module tmc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_req = '0;
  logic [2:0]  acc_evt = '0;
  logic        priv_evt = 1'b0, pc_neg = 1'b0, sec_evt = 1'b0;
  logic [63:0] cause_we = '0, cause_wd = '0, mask_we = '0, mask_wd = '0;
  logic [63:0] cause_q, mask_q;
  logic        trap_req;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tmc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .acc_evt(acc_evt),
    .priv_evt(priv_evt), .pc_neg(pc_neg), .sec_evt(sec_evt),
    .cause_we(cause_we), .cause_wd(cause_wd), .mask_we(mask_we),
    .mask_wd(mask_wd), .cause_q(cause_q), .mask_q(mask_q), .trap_req(trap_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    io_req = '0; acc_evt = '0; priv_evt = 0; sec_evt = 0;
    cause_we = '0; cause_wd = '0; mask_we = '0; mask_wd = '0;
  endtask

  // apply current inputs for one edge, then sample point
  task automatic tick();
    @(posedge clk); #2;
    idle_all();
  endtask

  task automatic do_reset();
    idle_all(); pc_neg = 0; rst_n = 0;
    @(posedge clk); @(posedge clk); #2;
    rst_n = 1;
  endtask

  task automatic t_reset();
    rst_n = 0;
    @(posedge clk); #2;
    rst_n = 1;
    chk("R1 cause", cause_q, 64'h0);
    chk("R1 mask", mask_q, 64'h0);
    chk("R1 trap", {63'h0, trap_req}, 64'h0);
  endtask

  task automatic t_io();
    do_reset();
    io_req[3] = 1; tick();
    chk("R2 io set", cause_q, 64'h8);
    chk("R2 no trap", {63'h0, trap_req}, 64'h0);
    tick(); tick(); tick();
    chk("R2 held", cause_q, 64'h8);
    mask_we[3] = 1; mask_wd[3] = 1; tick();
    chk("R3 late mask trap", {63'h0, trap_req}, 64'h1);
    cause_we[3] = 1; cause_wd[3] = 0; tick();
    chk("R2 sw clear", cause_q, 64'h0);
    chk("R3 trap drops", {63'h0, trap_req}, 64'h0);
  endtask

  task automatic t_sec();
    do_reset();
    sec_evt = 1; tick();
    chk("R4 cause", cause_q, 64'h1000);
    chk("R4 mask forced", mask_q, 64'h1000);
    chk("R4 trap", {63'h0, trap_req}, 64'h1);
    mask_we[12] = 1; mask_wd[12] = 0; tick();
    chk("R5 mask cleared", mask_q, 64'h0);
    chk("R5 still traps", {63'h0, trap_req}, 64'h1);
    cause_we[12] = 1; cause_wd[12] = 0; tick();
    chk("R5 trap after clear", {63'h0, trap_req}, 64'h0);
  endtask

  task automatic t_priv();
    do_reset();
    priv_evt = 1; tick();
    chk("R6 not recorded", cause_q, 64'h0);
    chk("R6 no trap", {63'h0, trap_req}, 64'h0);
    mask_we[11] = 1; mask_wd[11] = 1; tick();
    pc_neg = 1; priv_evt = 1; tick();
    chk("R7 negative pc ignored", cause_q, 64'h0);
    pc_neg = 0; priv_evt = 1; tick();
    chk("R7 recorded", cause_q, 64'h800);
    chk("R7 trap", {63'h0, trap_req}, 64'h1);
  endtask

  task automatic t_write();
    do_reset();
    cause_we = 64'h21; cause_wd = '1; tick();
    chk("R8 cause enables", cause_q, 64'h21);
    mask_we[63] = 1; mask_wd = '1; tick();
    chk("R8 mask top bit", mask_q, 64'h8000_0000_0000_0000);
    chk("R8 no trap", {63'h0, trap_req}, 64'h0);
  endtask

  task automatic t_collide();
    do_reset();
    io_req = 8'h14; cause_we[2] = 1; cause_we[4] = 1; cause_wd[4] = 1; tick();
    chk("R9 clear wins, set stays", cause_q, 64'h10);
    sec_evt = 1; mask_we[12] = 1; mask_wd[12] = 0; tick();
    chk("R9 mask clear wins", mask_q, 64'h0);
    chk("R9 cause still set", cause_q, 64'h1010);
  endtask

  task automatic t_access();
    do_reset();
    acc_evt = 3'b010; tick();
    chk("R10 recorded", cause_q, 64'h200);
    chk("R10 held back", {63'h0, trap_req}, 64'h0);
    mask_we[9] = 1; mask_wd[9] = 1; tick();
    chk("R10 delivered", {63'h0, trap_req}, 64'h1);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(posedge clk); #2;
    t_reset();
    t_io();
    t_sec();
    t_priv();
    t_write();
    t_collide();
    t_access();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule